// File: doc/BRIEF.md
# Serial Configuration Target with Chain Pass-Through

This block is the receiving end of a clocked serial configuration port in a programmable device. A host drives a configuration clock and a one-bit data line. The block first clears its configuration store while it holds an active-low initialization line, and then releases that line. When the line is seen high, the block samples a 3-bit mode input. If the mode selects serial target operation, the block shifts in one fixed-length frame. The frame is a payload followed by a 16-bit CRC.

A good CRC releases the completion line. A bad CRC pulls the initialization line low again. Once the frame is complete, every further data bit is repeated on a chain output, so a downstream device can be loaded from the same stream. A low level on the program input restarts the whole sequence.

Both open-drain lines are modelled as a drive-low enable. The block also has a sensed-level input for the initialization line, because other devices on the line may hold it low. The configuration clock must be synchronous to the system clock, with each of its levels held for at least one system clock cycle. The block detects the configuration clock's edges by sampling it with the system clock.

Top module: `serial_cfg_target`

## Requirements
- R1: During reset, and while the block is clearing, it must hold init_drive_low=1, done_drive_low=1, chain_dout=0 and cfg_image=0. Clearing lasts exactly CLEAR_CYCLES system clock edges after reset or program release, and init_drive_low falls at the end of that count.
- R2: Configuration clock edges that occur while prog_n is low or while clearing is in progress must not change the store or the frame position.
- R3: The block must sample mode_sel once, at the first clock edge after clearing at which init_sense is high. Only the value 3'b111 may accept a frame. Any other value leaves cfg_image at 0 and done_drive_low at 1. A change of mode_sel after sampling must have no effect.
- R4: While init_sense is held low after clearing, the block must keep init_drive_low at 0 and ignore data bits.
- R5: A configuration clock rising edge is recognised at the first system clock edge at which cfg_clk is 1 after having been 0. On that edge the block captures cfg_din. Payload bits must be shifted into cfg_image so that the first bit received ends up in the most significant bit.
- R6: The last 16 bits of the frame must be a CRC-16 over the payload. The CRC uses polynomial 0x1021, start value 0xFFFF, most significant bit first, no final inversion, and it is sent most significant bit first. On a match, done_drive_low must fall at the clock edge that recognises the final bit, and not before.
- R7: On a CRC mismatch, init_drive_low must return to 1 and done_drive_low must stay at 1 until the next program pulse, whatever bits follow.
- R8: chain_dout must stay 0 until the frame is complete. After that, whatever the CRC result, each further captured bit must appear on chain_dout at the edge that recognises the following falling edge of cfg_clk.
- R9: While prog_n is low, the block must clear cfg_image and chain_dout and assert both drive-low outputs from any state. On release, it must restart with clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk | input | 1 | Configuration clock from the host |
| cfg_din | input | 1 | Serial configuration data |
| mode_sel | input | 3 | Mode select, sampled once per configuration |
| prog_n | input | 1 | Active-low program/restart request |
| init_sense | input | 1 | Sensed level of the shared initialization line |
| init_drive_low | output | 1 | Pull the initialization line low |
| done_drive_low | output | 1 | Pull the completion line low |
| chain_dout | output | 1 | Pass-through data to the next device in the chain |
| cfg_image | output | PAYLOAD_BITS | Contents of the configuration store |

## Verification
Clearing ends exactly CLEAR_CYCLES edges after program release. The bench samples init_drive_low one cycle before and one cycle after that point. A configuration clock edge takes effect at the first system clock edge after the bench changes cfg_clk. For this reason the bench holds each cfg_clk level for three cycles and reads outputs on the falling system clock edge, never at the edge where they change. The completion line is checked just before the final rising edge and again after it. Pass-through bits are checked three cycles after each falling configuration clock edge, against the bit captured on the rising edge before it.

// File: rtl/sct_pkg.sv
package sct_pkg;
    // ST_CLEAR must encode as zero: the controller resets its state struct to all zeros
    typedef enum logic [2:0] {
        ST_CLEAR = 3'd0,
        ST_WAIT  = 3'd1,
        ST_LOAD  = 3'd2,
        ST_IDLE  = 3'd3,
        ST_GOOD  = 3'd4,
        ST_BAD   = 3'd5
    } sct_state_e;
endpackage

// File: rtl/sct_edge.sv
module sct_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl;
        rise  = lvl & ~lvl_q;
        fall  = ~lvl & lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/sct_crc.sv
module sct_crc #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021,
    parameter logic [W-1:0] INIT = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] crc_nxt
);
    logic [W-1:0] crc_d, crc_q;
    logic         fb;

    always_comb begin
        fb      = crc_q[W-1] ^ bit_in;
        crc_nxt = {crc_q[W-2:0], 1'b0} ^ (POLY & {W{fb}});
        crc_d   = crc_q;
        if (clr)     crc_d = INIT;
        else if (en) crc_d = crc_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/sct_store.sv
module sct_store #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] image
);
    logic [W-1:0] img_d, img_q;

    always_comb begin
        img_d = img_q;
        if (clr)     img_d = '0;
        else if (en) img_d = {img_q[W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) img_q <= '0;
        else        img_q <= img_d;
    end

    assign image = img_q;
endmodule

// File: rtl/serial_cfg_target.sv
module serial_cfg_target #(
    parameter int           PAYLOAD_BITS = 32,
    parameter int           CLEAR_CYCLES = 8,
    parameter logic [2:0]   MODE_CODE    = 3'b111,
    parameter logic [15:0]  CRC_POLY     = 16'h1021,
    parameter logic [15:0]  CRC_INIT     = 16'hFFFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_clk,
    input  logic                    cfg_din,
    input  logic [2:0]              mode_sel,
    input  logic                    prog_n,
    input  logic                    init_sense,
    output logic                    init_drive_low,
    output logic                    done_drive_low,
    output logic                    chain_dout,
    output logic [PAYLOAD_BITS-1:0] cfg_image
);
    import sct_pkg::*;

    localparam int CRC_W      = 16;
    localparam int FRAME_BITS = PAYLOAD_BITS + CRC_W;
    localparam int BIT_CNT_W  = $clog2(FRAME_BITS + 1);
    localparam int CLR_CNT_W  = $clog2(CLEAR_CYCLES + 1);

    typedef struct packed {
        sct_state_e           state;
        logic [CLR_CNT_W-1:0] clr_cnt;
        logic [BIT_CNT_W-1:0] bit_cnt;
        logic                 fwd_bit;
        logic                 dout;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic rise, fall;
    logic store_clr, store_en, crc_clr, crc_en;
    logic [CRC_W-1:0] crc_nxt;

    sct_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (cfg_clk),
        .rise (rise),
        .fall (fall)
    );

    sct_crc #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .en     (crc_en),
        .bit_in (cfg_din),
        .crc_nxt(crc_nxt)
    );

    sct_store #(.W(PAYLOAD_BITS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (store_clr),
        .en    (store_en),
        .bit_in(cfg_din),
        .image (cfg_image)
    );

    always_comb begin
        ctl_d     = ctl_q;
        store_clr = 1'b0;
        store_en  = 1'b0;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;
        if (!prog_n) begin
            ctl_d.state   = ST_CLEAR;
            ctl_d.clr_cnt = '0;
            ctl_d.bit_cnt = '0;
            ctl_d.fwd_bit = 1'b0;
            ctl_d.dout    = 1'b0;
            store_clr     = 1'b1;
            crc_clr       = 1'b1;
        end else begin
            unique case (ctl_q.state)
                ST_CLEAR: begin
                    store_clr = 1'b1;
                    crc_clr   = 1'b1;
                    if (ctl_q.clr_cnt == CLR_CNT_W'(CLEAR_CYCLES - 1)) begin
                        ctl_d.clr_cnt = '0;
                        ctl_d.state   = ST_WAIT;
                    end else begin
                        ctl_d.clr_cnt = ctl_q.clr_cnt + CLR_CNT_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (init_sense)
                        ctl_d.state = (mode_sel == MODE_CODE) ? ST_LOAD : ST_IDLE;
                end
                ST_LOAD: begin
                    if (rise) begin
                        crc_en        = 1'b1;
                        store_en      = ctl_q.bit_cnt < BIT_CNT_W'(PAYLOAD_BITS);
                        ctl_d.bit_cnt = ctl_q.bit_cnt + BIT_CNT_W'(1);
                        if (ctl_q.bit_cnt == BIT_CNT_W'(FRAME_BITS - 1))
                            ctl_d.state = (crc_nxt == '0) ? ST_GOOD : ST_BAD;
                    end
                end
                ST_GOOD, ST_BAD: begin
                    if (rise) ctl_d.fwd_bit = cfg_din;
                    if (fall) ctl_d.dout    = ctl_q.fwd_bit;
                end
                ST_IDLE: ;
                default: ctl_d.state = ST_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign init_drive_low = (ctl_q.state == ST_CLEAR) || (ctl_q.state == ST_BAD);
    assign done_drive_low = (ctl_q.state != ST_GOOD);
    assign chain_dout     = ctl_q.dout;

    // R9: program request forces the cleared, held-low condition
    a_r9_prog_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |=> init_drive_low && done_drive_low && !chain_dout && (cfg_image == '0));

    // R1: the initialization line is released only at the end of the clearing count
    a_r1_release_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_drive_low) |-> $past(ctl_q.clr_cnt == CLR_CNT_W'(CLEAR_CYCLES - 1)) && $past(prog_n));

    // R2: the store changes only while loading or clearing
    a_r2_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_image) |-> $past(ctl_q.state == ST_LOAD) || $past(!prog_n)
                                || $past(ctl_q.state == ST_CLEAR));

    // R3: loading starts only with the serial mode code on a high init line
    a_r3_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.state == ST_LOAD) |-> $past(mode_sel == MODE_CODE) && $past(init_sense));

    // R6: completion is released only by the final frame bit
    a_r6_done_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_drive_low) |-> $past(ctl_q.state == ST_LOAD) && $past(rise)
                                  && $past(ctl_q.bit_cnt == BIT_CNT_W'(FRAME_BITS - 1)));

    // R7: a CRC failure holds both lines low until a program request
    a_r7_bad_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_BAD) && prog_n |=> init_drive_low && done_drive_low);

    // R8: the pass-through output moves only on a falling configuration clock edge
    a_r8_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chain_dout) |-> $past(fall) || $past(!prog_n));
endmodule

// File: tb/tb_serial_cfg_target.sv
`timescale 1ns/1ps
module tb_serial_cfg_target;
    localparam int PW   = 32;
    localparam int FW   = PW + 16;
    localparam int CC   = 8;
    localparam int HALF = 3;

    logic clk = 1'b0, rst_n = 1'b0, cfg_clk = 1'b0, cfg_din = 1'b0;
    logic prog_n = 1'b1, ext_hold = 1'b0;
    logic [2:0] mode_sel = 3'b111;
    logic init_sense, init_drive_low, done_drive_low, chain_dout;
    logic [PW-1:0] cfg_image;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    assign init_sense = ~init_drive_low & ~ext_hold;

    always #2 clk = ~clk;

    serial_cfg_target #(.PAYLOAD_BITS(PW), .CLEAR_CYCLES(CC)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_din(cfg_din),
        .mode_sel(mode_sel), .prog_n(prog_n), .init_sense(init_sense),
        .init_drive_low(init_drive_low), .done_drive_low(done_drive_low),
        .chain_dout(chain_dout), .cfg_image(cfg_image)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_of(input logic [PW-1:0] p);
        logic [15:0] c = 16'hFFFF;
        for (int i = PW - 1; i >= 0; i--) begin
            logic fb = c[15] ^ p[i];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    // one configuration clock period; optional check of chain_dout after the fall
    task automatic send_bit(input logic b, input bit do_chk, input logic exp, input string req);
        cfg_clk = 1'b0;
        cfg_din = b;
        repeat (HALF) @(negedge clk);
        if (do_chk) chk(req, chain_dout, exp);
        cfg_clk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_frame(input logic [FW-1:0] fr);
        for (int i = 0; i < FW; i++) begin
            if (i == FW - 1) chk("R6 done not early", done_drive_low, 1'b1);
            send_bit(fr[FW-1-i], 1'b1, 1'b0, "R8 quiet before full");
        end
    endtask

    task automatic restart();
        prog_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 lines held", {init_drive_low, done_drive_low, chain_dout}, 3'b110);
        chk("R9 store cleared", cfg_image, '0);
        prog_n = 1'b1;
        repeat (CC + 2) @(negedge clk);
    endtask

    function automatic logic [PW-1:0] pattern(input int k);
        case (k)
            0:       return '0;
            1:       return '1;
            2:       return 32'hA5A5_5A5A;
            3:       return 32'h8000_0001;
            default: return 32'h1234_5678 * k + 32'h0F0F;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] p;
        logic [FW-1:0] fr;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset lines", {init_drive_low, done_drive_low, chain_dout}, 3'b110);
        chk("R1 reset store", cfg_image, '0);
        rst_n = 1'b1;
        repeat (CC - 1) @(negedge clk);
        chk("R1 still clearing", init_drive_low, 1'b1);
        @(negedge clk);
        chk("R1 released on count", init_drive_low, 1'b0);
        repeat (2) @(negedge clk);

        // R2: edges during program-low and clearing are ignored
        prog_n = 1'b0;
        repeat (2) @(negedge clk);
        send_bit(1'b1, 1'b0, 1'b0, "");
        prog_n = 1'b1;
        send_bit(1'b1, 1'b0, 1'b0, "");
        repeat (CC - 2 * HALF + 2) @(negedge clk);
        p = 32'h0000_0F00;
        send_frame({p, crc_of(p)});
        chk("R2 clear-time bits ignored", cfg_image, p);
        chk("R2 frame accepted", done_drive_low, 1'b0);

        // R5 R6 R8: payload sweep with pass-through
        for (int k = 0; k < 6; k++) begin
            logic [7:0] x;
            p = pattern(k);
            x = p[7:0] ^ 8'h96;
            restart();
            send_frame({p, crc_of(p)});
            chk("R5 image order", cfg_image, p);
            chk("R6 done released", done_drive_low, 1'b0);
            chk("R6 init stays high", init_drive_low, 1'b0);
            for (int j = 0; j < 8; j++)
                send_bit(x[7-j], 1'b1, (j == 0) ? 1'b0 : x[8-j], "R8 pass-through");
            send_bit(1'b0, 1'b1, x[0], "R8 pass-through last");
            chk("R8 image unchanged by extra bits", cfg_image, p);
        end

        // R7: every single-bit error across the frame
        p = 32'hC0FF_EE11;
        for (int k = 0; k < FW; k++) begin
            fr = {p, crc_of(p)} ^ (48'd1 << k);
            restart();
            send_frame(fr);
            chk("R7 init driven low", init_drive_low, 1'b1);
            chk("R7 done held", done_drive_low, 1'b1);
            send_bit(1'b1, 1'b0, 1'b0, "");
            send_bit(1'b0, 1'b1, 1'b1, "R8 pass-through after bad frame");
            chk("R7 done still held", done_drive_low, 1'b1);
        end

        // R3: every other mode code rejects the frame
        p = 32'h5EED_1234;
        for (int m = 0; m < 7; m++) begin
            mode_sel = 3'(m);
            restart();
            send_frame({p, crc_of(p)});
            chk("R3 wrong mode store", cfg_image, '0);
            chk("R3 wrong mode done", done_drive_low, 1'b1);
        end
        mode_sel = 3'b111;
        restart();
        mode_sel = 3'b000;
        send_frame({p, crc_of(p)});
        chk("R3 mode sampled once", {done_drive_low, cfg_image}, {1'b0, p});
        mode_sel = 3'b111;

        // R4: init line held low externally
        ext_hold = 1'b1;
        restart();
        chk("R4 block releases line", init_drive_low, 1'b0);
        send_bit(1'b1, 1'b0, 1'b0, "");
        repeat (4) @(negedge clk);
        chk("R4 bits ignored while held", cfg_image, '0);
        ext_hold = 1'b0;
        repeat (2) @(negedge clk);
        p = 32'h0BAD_F00D;
        send_frame({p, crc_of(p)});
        chk("R4 load after release", {done_drive_low, cfg_image}, {1'b0, p});

        // R9: program pulse in mid-load
        restart();
        for (int j = 0; j < 10; j++) send_bit(1'b1, 1'b0, 1'b0, "");
        restart();
        p = 32'h7654_3210;
        send_frame({p, crc_of(p)});
        chk("R9 reload after abort", {done_drive_low, cfg_image}, {1'b0, p});

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule